// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block chooses the power state of every DRAM rank behind one memory controller. It drives one clock-enable line per rank and works from three inputs: the package power state, per-rank request-pending flags and the graphics and display activity flags. In the running package states each rank drops into power-down after its own idle period. It returns to active when a request targets it, and it is held back from the scheduler for a fixed exit latency. Power-down comes in two kinds. Active power-down lowers clock enable and leaves rows open. Precharge power-down first asks the command scheduler for a precharge-all to the rank and waits for the acknowledge.

A refresh-due strobe wakes every sleeping rank. The block then signals that refresh may start, and once refresh completes it puts every idle rank back to sleep at once. In the deep idle package state the block moves all ranks into self-refresh when no request is pending, and under internal graphics also when graphics is idle, no display fetch is waiting and only one display is active. Self-refresh entry and exit are handshakes with the command scheduler. Suspend-to-RAM drains traffic and then holds self-refresh. Hibernate drops clock enable and flags the memory contents as lost.

Top module: `dram_rank_pwr_ctrl`

## Requirements
- R1: After reset every clock-enable and ready bit is 1, every rank status field is 0, and pre_req, sr_enter_req, sr_exit_req, refresh_go and mem_invalid are 0.
- R2: With pd_enable=1 in package state 0 (C0/C1/C1E), a rank whose request flag stays low enters power-down on the (idle_limit+1)-th consecutive idle clock edge. A high request flag restarts that count. Each rank counts on its own.
- R3: With pd_mode=0 (active power-down) the rank enters power-down with clock enable low and status 1 (rank i uses rank_status bits 2i+1:2i), and raises no precharge request.
- R4: With pd_mode=1 (precharge power-down) the rank first raises pre_req with clock enable still high and status 0, and stays that way until pre_ack. On the next edge clock enable goes low and status becomes 2.
- R5: A request to a powered-down rank raises its clock enable on the next edge, and its ready bit rises exactly 4 edges after that.
- R6: After refresh_due, every powered-down rank is woken. refresh_go is high only while all ranks are active. After refresh_done every rank with no pending request re-enters power-down on the following edge, without waiting for its idle count.
- R7: In package state 1 (C3/C6) with gfx_internal=0 and no pending request, all ranks are woken and sr_enter_req is raised. After sr_enter_ack all clock enables are low and all status fields are 3.
- R8: With gfx_internal=1, self-refresh entry in state 1 also requires gfx_idle=1, disp_pending=0 and single_disp=1. Otherwise per-rank idle power-down continues.
- R9: In package state 2 (S3) self-refresh entry waits until no request is pending. The ranks then stay in self-refresh with clock enables low for as long as state 2 lasts, whatever the requests.
- R10: Self-refresh is left when the package state returns to 0, or when a request arrives in state 1. sr_exit_req is raised with clock enables high and ready low until sr_exit_ack, after which all ranks are ready.
- R11: Package state 3 (S4) drives all clock enables low and all status fields to 3, and sets mem_invalid. That condition holds until reset.
- R12: With pd_enable=0 no rank powers down, whatever the idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkg_state | input | 2 | Package state: 0 C0/C1/C1E, 1 C3/C6, 2 S3, 3 S4 |
| req_pending | input | NUM_RANKS | Per-rank request pending |
| refresh_due | input | 1 | Refresh needed strobe |
| refresh_done | input | 1 | Refresh finished strobe |
| gfx_internal | input | 1 | 1 = internal graphics configuration |
| gfx_idle | input | 1 | Graphics engine idle |
| disp_pending | input | 1 | Display request pending |
| single_disp | input | 1 | Single display mode |
| pd_enable | input | 1 | Dynamic power-down enable |
| pd_mode | input | 1 | 0 active power-down, 1 precharge power-down |
| idle_limit | input | IDLE_W | Idle cycles before power-down |
| pre_ack | input | NUM_RANKS | Precharge-all acknowledge per rank |
| sr_enter_ack | input | 1 | Self-refresh entry acknowledge |
| sr_exit_ack | input | 1 | Self-refresh exit acknowledge |
| cke | output | NUM_RANKS | Clock enable per rank |
| rank_ready | output | NUM_RANKS | Rank may accept commands |
| rank_status | output | 2*NUM_RANKS | Per-rank state code 0..3 |
| pre_req | output | NUM_RANKS | Precharge-all request per rank |
| sr_enter_req | output | 1 | Self-refresh entry request |
| sr_exit_req | output | 1 | Self-refresh exit request |
| refresh_go | output | 1 | All ranks awake, refresh may start |
| mem_invalid | output | 1 | Memory contents lost |

## Verification
Some properties are checked on every cycle. Precharge power-down is entered only after an acknowledge. A wake request always raises clock enable on the next edge. A disabled power-down never leaves the active state. Self-refresh entry starts only from a drained, non-running package state. An exit request holds until its acknowledge. Suspend keeps self-refresh, hibernate sets the invalid flag, and refresh is never granted with any rank asleep. The exact idle and exit-latency cycle counts, the restart of the idle count, the re-sleep after refresh, the graphics and display gating, and the stickiness of the hibernate state through later package changes can only be shown by the bench's timed scenarios.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;

  typedef enum logic [1:0] {
    PKG_RUN  = 2'd0,
    PKG_DEEP = 2'd1,
    PKG_S3   = 2'd2,
    PKG_S4   = 2'd3
  } pkg_e;

  typedef enum logic [2:0] {
    R_ACT,
    R_PRE,
    R_APD,
    R_PPD,
    R_WAKE
  } rank_st_e;

  typedef enum logic [2:0] {
    G_RUN,
    G_SR_ENTER,
    G_SR,
    G_SR_EXIT,
    G_OFF
  } glob_e;

  localparam logic [1:0] ST_ACT = 2'd0;
  localparam logic [1:0] ST_APD = 2'd1;
  localparam logic [1:0] ST_PPD = 2'd2;
  localparam logic [1:0] ST_SR  = 2'd3;

endpackage

// File: rtl/rank_pd_fsm.sv
module rank_pd_fsm
  import dram_pwr_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int EXIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              req,
  input  logic              pd_en,
  input  logic              pd_mode,
  input  logic              wake,
  input  logic              sleep_now,
  input  logic              pre_ack,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              cke,
  output logic              ready,
  output logic              pre_req,
  output logic [1:0]        status
);
  localparam int LAT_W = (EXIT_LAT > 1) ? $clog2(EXIT_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(EXIT_LAT - 1);

  rank_st_e st, st_n;
  logic [IDLE_W-1:0] idle_cnt;
  logic [LAT_W-1:0]  lat_cnt;
  logic              pd_go;

  assign pd_go = pd_en && !wake && !req && (sleep_now || (idle_cnt >= idle_limit));

  always_comb begin
    st_n = st;
    unique case (st)
      R_ACT:        if (pd_go) st_n = pd_mode ? R_PRE : R_APD;
      R_PRE:        if (pre_ack) st_n = R_PPD;
      R_APD, R_PPD: if (req || wake || !pd_en) st_n = R_WAKE;
      R_WAKE:       if (lat_cnt == LAT_LAST) st_n = R_ACT;
      default:      st_n = R_ACT;
    endcase
    if (hold) st_n = R_ACT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= R_ACT;
      idle_cnt <= '0;
      lat_cnt  <= '0;
    end else begin
      st <= st_n;
      if (hold || req || st != R_ACT || st_n != R_ACT)
        idle_cnt <= '0;
      else if (idle_cnt != '1)
        idle_cnt <= idle_cnt + 1'b1;
      if (st == R_WAKE && st_n == R_WAKE)
        lat_cnt <= lat_cnt + 1'b1;
      else
        lat_cnt <= '0;
    end
  end

  always_comb begin
    cke     = !(st == R_APD || st == R_PPD);
    ready   = (st == R_ACT);
    pre_req = (st == R_PRE);
    unique case (st)
      R_APD:   status = ST_APD;
      R_PPD:   status = ST_PPD;
      default: status = ST_ACT;
    endcase
  end

  // R4: precharge power-down is only reached through an acknowledge
  a_r4_ppd_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(st == R_PPD) |-> $past(pre_ack));

  // R5: a request to a sleeping rank raises clock enable on the next edge
  a_r5_wake_cke: assert property (@(posedge clk) disable iff (rst)
    ((st == R_APD || st == R_PPD) && req) |=> cke);

  // R12: with power-down disabled an active rank stays active
  a_r12_stay_active: assert property (@(posedge clk) disable iff (rst)
    (!pd_en && st == R_ACT) |=> (st == R_ACT));

  // R3: active mode never requests a precharge-all
  a_r3_no_pre_active: assert property (@(posedge clk) disable iff (rst)
    (st == R_ACT && !pd_mode) |=> !pre_req);

endmodule

// File: rtl/refresh_wake.sv
module refresh_wake (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic refresh_due,
  input  logic refresh_done,
  input  logic ranks_active,
  output logic ref_busy,
  output logic sleep_now,
  output logic refresh_go
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_busy  <= 1'b0;
      sleep_now <= 1'b0;
    end else begin
      sleep_now <= allow && ref_busy && refresh_done;
      if (!allow)
        ref_busy <= 1'b0;
      else if (ref_busy && refresh_done)
        ref_busy <= 1'b0;
      else if (refresh_due)
        ref_busy <= 1'b1;
    end
  end

  assign refresh_go = ref_busy && ranks_active && allow;

  // R6: the re-sleep pulse only follows a refresh that was in progress
  a_r6_sleep_follows: assert property (@(posedge clk) disable iff (rst)
    sleep_now |-> $past(ref_busy && refresh_done));

endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
  import dram_pwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pkg_e  pkg,
  input  logic  any_req,
  input  logic  gfx_internal,
  input  logic  gfx_idle,
  input  logic  disp_pending,
  input  logic  single_disp,
  input  logic  ranks_active,
  input  logic  ref_busy,
  input  logic  sr_enter_ack,
  input  logic  sr_exit_ack,
  output glob_e mode,
  output logic  sr_want,
  output logic  sr_enter_req,
  output logic  sr_exit_req,
  output logic  mem_invalid
);
  glob_e mode_n;
  logic  gfx_ok;

  assign gfx_ok  = !gfx_internal || (gfx_idle && !disp_pending && single_disp);
  assign sr_want = !any_req && ((pkg == PKG_S3) || (pkg == PKG_DEEP && gfx_ok));

  always_comb begin
    mode_n = mode;
    unique case (mode)
      G_RUN:      if (sr_want && ranks_active && !ref_busy) mode_n = G_SR_ENTER;
      G_SR_ENTER: if (sr_enter_ack) mode_n = G_SR;
      G_SR:       if (pkg == PKG_RUN || (pkg == PKG_DEEP && any_req)) mode_n = G_SR_EXIT;
      G_SR_EXIT:  if (sr_exit_ack) mode_n = G_RUN;
      default:    mode_n = G_OFF;
    endcase
    if (pkg == PKG_S4) mode_n = G_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= G_RUN;
      mem_invalid <= 1'b0;
    end else begin
      mode        <= mode_n;
      mem_invalid <= mem_invalid || (mode_n == G_OFF);
    end
  end

  assign sr_enter_req = (mode == G_SR_ENTER);
  assign sr_exit_req  = (mode == G_SR_EXIT);

  // R7: entry starts only with traffic drained and outside the running state
  a_r7_enter_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_enter_req) |-> $past(!any_req && pkg != PKG_RUN));

  // R10: an exit request holds until acknowledged
  a_r10_exit_hold: assert property (@(posedge clk) disable iff (rst)
    (sr_exit_req && !sr_exit_ack && pkg != PKG_S4) |=> sr_exit_req);

  // R9: suspend keeps self-refresh
  a_r9_s3_stays: assert property (@(posedge clk) disable iff (rst)
    (mode == G_SR && pkg == PKG_S3) |=> (mode == G_SR));

  // R11: hibernate marks the contents lost
  a_r11_s4_invalid: assert property (@(posedge clk) disable iff (rst)
    (pkg == PKG_S4) |=> mem_invalid);

endmodule

// File: rtl/dram_rank_pwr_ctrl.sv
module dram_rank_pwr_ctrl
  import dram_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_W    = 8,
  parameter int EXIT_LAT  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             pkg_state,
  input  logic [NUM_RANKS-1:0]   req_pending,
  input  logic                   refresh_due,
  input  logic                   refresh_done,
  input  logic                   gfx_internal,
  input  logic                   gfx_idle,
  input  logic                   disp_pending,
  input  logic                   single_disp,
  input  logic                   pd_enable,
  input  logic                   pd_mode,
  input  logic [IDLE_W-1:0]      idle_limit,
  input  logic [NUM_RANKS-1:0]   pre_ack,
  input  logic                   sr_enter_ack,
  input  logic                   sr_exit_ack,
  output logic [NUM_RANKS-1:0]   cke,
  output logic [NUM_RANKS-1:0]   rank_ready,
  output logic [2*NUM_RANKS-1:0] rank_status,
  output logic [NUM_RANKS-1:0]   pre_req,
  output logic                   sr_enter_req,
  output logic                   sr_exit_req,
  output logic                   refresh_go,
  output logic                   mem_invalid
);
  localparam int ST_W = 2;

  glob_e                mode;
  logic                 hold;
  logic                 sr_want;
  logic                 wake_all;
  logic                 ref_busy;
  logic                 sleep_now;
  logic                 ranks_active;
  logic [NUM_RANKS-1:0] rk_cke;
  logic [NUM_RANKS-1:0] rk_rdy;
  logic [NUM_RANKS-1:0] rk_pre;
  logic [ST_W-1:0]      rk_st [NUM_RANKS];

  assign hold         = (mode != G_RUN);
  assign ranks_active = &rk_rdy;
  assign wake_all     = ref_busy || sr_want;

  sr_sequencer u_seq (
    .clk          (clk),
    .rst          (rst),
    .pkg          (pkg_e'(pkg_state)),
    .any_req      (|req_pending),
    .gfx_internal (gfx_internal),
    .gfx_idle     (gfx_idle),
    .disp_pending (disp_pending),
    .single_disp  (single_disp),
    .ranks_active (ranks_active),
    .ref_busy     (ref_busy),
    .sr_enter_ack (sr_enter_ack),
    .sr_exit_ack  (sr_exit_ack),
    .mode         (mode),
    .sr_want      (sr_want),
    .sr_enter_req (sr_enter_req),
    .sr_exit_req  (sr_exit_req),
    .mem_invalid  (mem_invalid)
  );

  refresh_wake u_ref (
    .clk          (clk),
    .rst          (rst),
    .allow        (!hold),
    .refresh_due  (refresh_due),
    .refresh_done (refresh_done),
    .ranks_active (ranks_active),
    .ref_busy     (ref_busy),
    .sleep_now    (sleep_now),
    .refresh_go   (refresh_go)
  );

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    rank_pd_fsm #(
      .IDLE_W   (IDLE_W),
      .EXIT_LAT (EXIT_LAT)
    ) u_rank (
      .clk        (clk),
      .rst        (rst),
      .hold       (hold),
      .req        (req_pending[i]),
      .pd_en      (pd_enable),
      .pd_mode    (pd_mode),
      .wake       (wake_all),
      .sleep_now  (sleep_now),
      .pre_ack    (pre_ack[i]),
      .idle_limit (idle_limit),
      .cke        (rk_cke[i]),
      .ready      (rk_rdy[i]),
      .pre_req    (rk_pre[i]),
      .status     (rk_st[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_RANKS; i++) begin
      unique case (mode)
        G_RUN: begin
          cke[i]                 = rk_cke[i];
          rank_ready[i]          = rk_rdy[i];
          pre_req[i]             = rk_pre[i];
          rank_status[ST_W*i +: ST_W] = rk_st[i];
        end
        G_SR_ENTER, G_SR_EXIT: begin
          cke[i]                 = 1'b1;
          rank_ready[i]          = 1'b0;
          pre_req[i]             = 1'b0;
          rank_status[ST_W*i +: ST_W] = ST_ACT;
        end
        default: begin
          cke[i]                 = 1'b0;
          rank_ready[i]          = 1'b0;
          pre_req[i]             = 1'b0;
          rank_status[ST_W*i +: ST_W] = ST_SR;
        end
      endcase
    end
  end

  // R6: refresh is granted only with every rank awake
  a_r6_refresh_awake: assert property (@(posedge clk) disable iff (rst)
    refresh_go |-> (&cke));

  // R7: an acknowledged entry drops every clock enable
  a_r7_sr_cke_low: assert property (@(posedge clk) disable iff (rst)
    (sr_enter_req && sr_enter_ack) |=> (cke == '0));

  // R11: hibernate holds clock enables low
  a_r11_s4_cke_low: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == 2'd3) |=> (cke == '0));

endmodule

// File: tb/dram_rank_pwr_ctrl_test.sv
`timescale 1ns/1ps
module dram_rank_pwr_ctrl_test;
  localparam int NR = 4;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    pkg_state = 2'd0;
  logic [NR-1:0] req_pending = '0;
  logic          refresh_due = 1'b0, refresh_done = 1'b0;
  logic          gfx_internal = 1'b0, gfx_idle = 1'b0, disp_pending = 1'b0, single_disp = 1'b0;
  logic          pd_enable = 1'b0, pd_mode = 1'b0;
  logic [IW-1:0] idle_limit = 8'd3;
  logic [NR-1:0] pre_ack = '0;
  logic          sr_enter_ack = 1'b0, sr_exit_ack = 1'b0;
  logic [NR-1:0] cke, rank_ready, pre_req;
  logic [2*NR-1:0] rank_status;
  logic          sr_enter_req, sr_exit_req, refresh_go, mem_invalid;

  dram_rank_pwr_ctrl #(.NUM_RANKS(NR), .IDLE_W(IW), .EXIT_LAT(4)) uut (
    .clk(clk), .rst(rst), .pkg_state(pkg_state), .req_pending(req_pending),
    .refresh_due(refresh_due), .refresh_done(refresh_done),
    .gfx_internal(gfx_internal), .gfx_idle(gfx_idle), .disp_pending(disp_pending),
    .single_disp(single_disp), .pd_enable(pd_enable), .pd_mode(pd_mode),
    .idle_limit(idle_limit), .pre_ack(pre_ack), .sr_enter_ack(sr_enter_ack),
    .sr_exit_ack(sr_exit_ack), .cke(cke), .rank_ready(rank_ready),
    .rank_status(rank_status), .pre_req(pre_req), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .refresh_go(refresh_go), .mem_invalid(mem_invalid)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          at;
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return 32'(cke);
      1: return 32'(rank_status);
      2: return 32'(rank_ready);
      3: return 32'(mem_invalid);
      4: return 32'(pre_req);
      5: return 32'(sr_enter_req);
      6: return 32'(sr_exit_req);
      default: return 32'(refresh_go);
    endcase
  endfunction

  function automatic string sel_name(int sel);
    case (sel)
      0: return "cke";
      1: return "rank_status";
      2: return "rank_ready";
      3: return "mem_invalid";
      4: return "pre_req";
      5: return "sr_enter_req";
      6: return "sr_exit_req";
      default: return "refresh_go";
    endcase
  endfunction

  // driver side: queue an expected value for the current cycle
  task automatic expect_out(int sel, logic [31:0] v, string tag);
    exp_t e;
    e.at = cyc; e.sel = sel; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].at <= cyc) begin
          logic [31:0] act;
          act = observe(q[k].sel);
          tests++;
          if (act !== q[k].val) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", q[k].tag, sel_name(q[k].sel), act, q[k].val);
          end
          q.delete(k);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    req_pending = 4'hF;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    expect_out(0, 32'hF, "R1"); expect_out(1, 32'h00, "R1"); expect_out(2, 32'hF, "R1");
    expect_out(3, 32'h0, "R1"); expect_out(4, 32'h0, "R1"); expect_out(5, 32'h0, "R1");
    expect_out(6, 32'h0, "R1"); expect_out(7, 32'h0, "R1");

    // R12 power-down disabled
    req_pending = 4'h0;
    step(10);
    expect_out(0, 32'hF, "R12");

    // R2/R3 idle count and active power-down
    req_pending = 4'hF; step(1);
    pd_enable = 1'b1; req_pending = 4'h1;
    step(3);
    expect_out(0, 32'hF, "R2");
    step(1);
    expect_out(0, 32'h1, "R2"); expect_out(1, 32'h54, "R3");
    expect_out(4, 32'h0, "R3"); expect_out(2, 32'h1, "R3");
    // R2 restart of the idle count on rank 0
    req_pending = 4'h0; step(2);
    req_pending = 4'h1; step(1);
    req_pending = 4'h0; step(3);
    expect_out(0, 32'h1, "R2");
    step(1);
    expect_out(0, 32'h0, "R2"); expect_out(1, 32'h55, "R3");

    // R5 wake with exit latency
    req_pending = 4'h4;
    step(1);
    expect_out(0, 32'h4, "R5"); expect_out(2, 32'h0, "R5");
    step(3);
    expect_out(2, 32'h0, "R5");
    step(1);
    expect_out(2, 32'h4, "R5");
    req_pending = 4'h0;
    step(6);
    expect_out(0, 32'h0, "R5");

    // R6 refresh wake and re-sleep
    idle_limit = 8'd40;
    refresh_due = 1'b1; step(1); refresh_due = 1'b0;
    expect_out(0, 32'h0, "R6"); expect_out(7, 32'h0, "R6");
    step(1);
    expect_out(0, 32'hF, "R6"); expect_out(7, 32'h0, "R6");
    step(3);
    expect_out(7, 32'h0, "R6");
    step(1);
    expect_out(7, 32'h1, "R6"); expect_out(0, 32'hF, "R6");
    refresh_done = 1'b1; step(1); refresh_done = 1'b0;
    expect_out(7, 32'h0, "R6"); expect_out(0, 32'hF, "R6");
    step(1);
    expect_out(0, 32'h0, "R6"); expect_out(1, 32'h55, "R6");

    // R4 precharge power-down
    pd_mode = 1'b1; idle_limit = 8'd2; req_pending = 4'hF;
    step(6);
    expect_out(2, 32'hF, "R4");
    req_pending = 4'hE;
    step(3);
    expect_out(4, 32'h1, "R4"); expect_out(0, 32'hF, "R4"); expect_out(1, 32'h00, "R4");
    step(2);
    expect_out(4, 32'h1, "R4"); expect_out(0, 32'hF, "R4");
    pre_ack = 4'h1; step(1); pre_ack = 4'h0;
    expect_out(0, 32'hE, "R4"); expect_out(1, 32'h02, "R4"); expect_out(4, 32'h0, "R4");

    // R7 external graphics self-refresh
    pkg_state = 2'd1; gfx_internal = 1'b0; req_pending = 4'h0;
    step(5);
    expect_out(5, 32'h0, "R7");
    step(1);
    expect_out(5, 32'h1, "R7"); expect_out(0, 32'hF, "R7");
    sr_enter_ack = 1'b1; step(1); sr_enter_ack = 1'b0;
    expect_out(0, 32'h0, "R7"); expect_out(1, 32'hFF, "R7");
    expect_out(2, 32'h0, "R7"); expect_out(5, 32'h0, "R7");

    // R10 exit on a request in the deep state
    req_pending = 4'h2;
    step(1);
    expect_out(6, 32'h1, "R10"); expect_out(0, 32'hF, "R10"); expect_out(2, 32'h0, "R10");
    step(3);
    expect_out(6, 32'h1, "R10"); expect_out(2, 32'h0, "R10");
    sr_exit_ack = 1'b1; step(1); sr_exit_ack = 1'b0;
    expect_out(2, 32'hF, "R10"); expect_out(6, 32'h0, "R10");

    // R8 internal graphics gating: multi-display blocks entry
    gfx_internal = 1'b1; gfx_idle = 1'b1; disp_pending = 1'b0; single_disp = 1'b0;
    req_pending = 4'h0;
    step(8);
    expect_out(5, 32'h0, "R8"); expect_out(4, 32'hF, "R8");
    pre_ack = 4'hF; step(1); pre_ack = 4'h0;
    expect_out(0, 32'h0, "R8"); expect_out(1, 32'hAA, "R8");
    single_disp = 1'b1;
    step(5);
    expect_out(5, 32'h0, "R8");
    step(1);
    expect_out(5, 32'h1, "R8");
    sr_enter_ack = 1'b1; step(1); sr_enter_ack = 1'b0;
    expect_out(1, 32'hFF, "R8");

    // R10 exit on return to the running state
    pd_mode = 1'b0; idle_limit = 8'd40; pkg_state = 2'd0;
    step(1);
    expect_out(6, 32'h1, "R10"); expect_out(2, 32'h0, "R10");
    sr_exit_ack = 1'b1; step(1); sr_exit_ack = 1'b0;
    expect_out(2, 32'hF, "R10");

    // R9 suspend drains then holds self-refresh
    pkg_state = 2'd2; req_pending = 4'h1;
    step(4);
    expect_out(5, 32'h0, "R9"); expect_out(2, 32'hF, "R9");
    req_pending = 4'h0;
    step(1);
    expect_out(5, 32'h1, "R9");
    sr_enter_ack = 1'b1; step(1); sr_enter_ack = 1'b0;
    expect_out(0, 32'h0, "R9");
    req_pending = 4'hF;
    step(3);
    expect_out(0, 32'h0, "R9"); expect_out(6, 32'h0, "R9"); expect_out(1, 32'hFF, "R9");

    // R11 hibernate
    pkg_state = 2'd3;
    step(1);
    expect_out(3, 32'h1, "R11"); expect_out(0, 32'h0, "R11"); expect_out(1, 32'hFF, "R11");
    pkg_state = 2'd0; req_pending = 4'h0;
    step(5);
    expect_out(3, 32'h1, "R11"); expect_out(0, 32'h0, "R11"); expect_out(2, 32'h0, "R11");

    // R1 reset clears the hibernate flag
    rst = 1'b1; step(2); rst = 1'b0;
    step(1);
    expect_out(3, 32'h0, "R1"); expect_out(0, 32'hF, "R1"); expect_out(2, 32'hF, "R1");

    step(3);
    if (q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule